// File: doc/BRIEF.md
# Streaming Run-Length Byte Encoder with Escape Tokens

This block sits in a byte stream and replaces runs of a repeated character with a short three-symbol token. The token is an escape marker, the repeated character, and the run length written as a single printable decimal digit. Short runs are copied through unchanged, because a token would be no shorter than the bytes it replaces. Packets enter on a valid/ready byte port with a last flag and leave on a valid/ready byte port with a last flag.

Inside the block there is only the character of the run being collected, its length, and a small emitter that holds up to three output symbols. A character that differs from the current run closes that run. So does reaching the longest length one digit can express, or the end of the packet. The closed run is then turned into symbols.

The marker character itself never starts a run. Each marker in the input becomes its own token carrying a count of one, so a decoder can always treat a marker as the start of a token.

Top module: `rle_escape_encoder`

## Requirements
- R1: A run of length one (a byte that differs from both neighbours) is output as that byte alone.
- R2: A run shorter than MIN_ENC (default 3, so lengths one and two) is output as that many copies of the character.
- R3: A run of length MIN_ENC or more is output as three symbols: marker 8'h40 ('@'), the character, then 8'h30 plus the length (an ASCII digit). For example, "ddeeeeeeeff" becomes "dd@e7ff".
- R4: A run longer than MAX_RUN (default 9) is cut. A token of length MAX_RUN is emitted first, and the remaining bytes are treated as a new run under R1 to R3. Twelve 'a' give "@a9@a3", and ten 'a' give "@a9a".
- R5: Every input byte equal to the marker 8'h40 is output as 8'h40, 8'h40, 8'h31 ("@@1"). Marker bytes never merge into a run, even when several arrive in a row.
- R6: Output symbols follow input order. A byte that differs from the current run closes that run and starts a new one.
- R7: When a byte with in_last is accepted, the pending run is flushed. out_last is high on the final symbol of the packet and on no other symbol. Runs never merge across a packet boundary.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold. Under any pattern of out_ready, no symbol is lost or repeated.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Encoder takes the offered byte this cycle |
| in_data | input | DATA_W | Input byte |
| in_last | input | 1 | Offered byte ends the packet |
| out_valid | output | 1 | Output symbol offered |
| out_ready | input | 1 | Sink takes the offered symbol this cycle |
| out_data | output | DATA_W | Output symbol |
| out_last | output | 1 | Offered symbol ends the packet |

## Verification
The hold-under-stall property assumes the sink's out_ready is the only cause of an output not being taken. The run-length bound assumes an input byte is counted only on a completed in_valid/in_ready handshake. The stimulus therefore changes in_data and in_last only after a byte has been accepted. Idle gaps on the input and random or long low periods on out_ready are inserted freely. The packets mix long runs, runs that reach exactly the split length, isolated and consecutive marker bytes, and single-byte packets that close immediately.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;

   // Number of symbol slots a single token may occupy.
   localparam int unsigned TOKEN_SLOTS = 3;

   // Run collector state.
   typedef enum logic [1:0] {
      TR_EMPTY   = 2'd0,
      TR_OPEN    = 2'd1,
      TR_CLOSING = 2'd2
   } tracker_state_t;

   // Form of the token produced for a closed run.
   typedef enum logic [1:0] {
      TK_LITERAL = 2'd0,
      TK_COUNTED = 2'd1,
      TK_MARKER  = 2'd2
   } token_kind_t;

endpackage

// File: rtl/rle_token_builder.sv
module rle_token_builder
   import rle_enc_pkg::*;
#(
   parameter int unsigned          DATA_W     = 8,
   parameter int unsigned          LEN_W      = 4,
   parameter int unsigned          MIN_ENC    = 3,
   parameter logic [DATA_W-1:0]    ESC_CHAR   = 'h40,
   parameter logic [DATA_W-1:0]    DIGIT_BASE = 'h30
) (
   input  logic [DATA_W-1:0]                   run_char,
   input  logic [LEN_W-1:0]                    run_len,
   output logic [TOKEN_SLOTS-1:0][DATA_W-1:0]  tok_sym,
   output logic [1:0]                          tok_cnt,
   output token_kind_t                         tok_kind
);

   localparam logic [LEN_W-1:0] ENC_LEN = LEN_W'(MIN_ENC);

   logic [DATA_W-1:0] digit;
   logic [TOKEN_SLOTS-1:0][DATA_W-1:0] lit_sym;

   assign digit = DIGIT_BASE + DATA_W'(run_len);

   // Literal form: every slot carries the character, count picks how many go out.
   for (genvar s = 0; s < TOKEN_SLOTS; s++) begin : g_lit_slot
      assign lit_sym[s] = run_char;
   end

   always_comb begin
      tok_kind = TK_LITERAL;
      tok_sym  = lit_sym;
      tok_cnt  = 2'(run_len);
      if (run_char == ESC_CHAR) begin
         tok_kind   = TK_MARKER;
         tok_sym[0] = ESC_CHAR;
         tok_sym[1] = ESC_CHAR;
         tok_sym[2] = digit;
         tok_cnt    = 2'd3;
      end else if (run_len >= ENC_LEN) begin
         tok_kind   = TK_COUNTED;
         tok_sym[0] = ESC_CHAR;
         tok_sym[1] = run_char;
         tok_sym[2] = digit;
         tok_cnt    = 2'd3;
      end
   end

endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
   import rle_enc_pkg::*;
#(
   parameter int unsigned          DATA_W   = 8,
   parameter int unsigned          LEN_W    = 4,
   parameter int unsigned          MAX_RUN  = 9,
   parameter logic [DATA_W-1:0]    ESC_CHAR = 'h40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_data,
   input  logic                in_last,
   input  logic                can_load,
   output logic [DATA_W-1:0]   run_char,
   output logic [LEN_W-1:0]    run_len,
   output logic                load,
   output logic                load_last
);

   localparam logic [LEN_W-1:0] CAP_LEN = LEN_W'(MAX_RUN);

   tracker_state_t state;
   logic accept;
   logic extend;
   logic closing_flush;

   assign in_ready      = can_load && (state != TR_CLOSING);
   assign accept        = in_valid && in_ready;
   assign extend        = (state == TR_OPEN) && (in_data == run_char) &&
                          (run_len < CAP_LEN) && (in_data != ESC_CHAR);
   assign closing_flush = (state == TR_CLOSING) && can_load;
   assign load          = (accept && (state == TR_OPEN) && !extend) || closing_flush;
   assign load_last     = (state == TR_CLOSING);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TR_EMPTY;
         run_char <= '0;
         run_len  <= '0;
      end else if (closing_flush) begin
         state    <= TR_EMPTY;
         run_len  <= '0;
      end else if (accept) begin
         if (extend) begin
            run_len <= run_len + 1'b1;
         end else begin
            run_char <= in_data;
            run_len  <= LEN_W'(1);
         end
         state <= in_last ? TR_CLOSING : TR_OPEN;
      end
   end

   AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (state != TR_EMPTY) |-> (run_len != '0 && run_len <= CAP_LEN)); // R4

   AST_MARKER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state != TR_EMPTY && run_char == ESC_CHAR) |-> (run_len == LEN_W'(1))); // R5

   AST_EMPTY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      closing_flush |=> (state == TR_EMPTY && run_len == '0)); // R7

   AST_CLOSE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> (state == TR_CLOSING)); // R7

endmodule

// File: rtl/rle_symbol_emitter.sv
module rle_symbol_emitter
   import rle_enc_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter bit          FAST_REFILL = 1'b0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load,
   input  logic [TOKEN_SLOTS-1:0][DATA_W-1:0]  ld_sym,
   input  logic [1:0]                          ld_cnt,
   input  logic                                ld_last,
   output logic                                can_load,
   output logic                                out_valid,
   input  logic                                out_ready,
   output logic [DATA_W-1:0]                   out_data,
   output logic                                out_last
);

   logic [TOKEN_SLOTS-1:0][DATA_W-1:0] slot;
   logic [1:0] cnt;
   logic       last_q;
   logic       pop;

   assign out_valid = (cnt != 2'd0);
   assign out_data  = slot[0];
   assign out_last  = last_q && (cnt == 2'd1);
   assign pop       = out_valid && out_ready;

   if (FAST_REFILL) begin : g_fast_refill
      // Refill in the same cycle the final symbol leaves.
      assign can_load = (cnt == 2'd0) || ((cnt == 2'd1) && out_ready);
   end else begin : g_drain_refill
      // Refill only once the slots are empty: no path from out_ready to in_ready.
      assign can_load = (cnt == 2'd0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot   <= '0;
         cnt    <= 2'd0;
         last_q <= 1'b0;
      end else if (load) begin
         slot   <= ld_sym;
         cnt    <= ld_cnt;
         last_q <= ld_last;
      end else if (pop) begin
         for (int s = 0; s < TOKEN_SLOTS - 1; s++) begin
            slot[s] <= slot[s+1];
         end
         cnt <= cnt - 2'd1;
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8

   AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> can_load); // R8

   AST_LOAD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (ld_cnt != 2'd0)); // R6

endmodule

// File: rtl/rle_escape_encoder.sv
module rle_escape_encoder
   import rle_enc_pkg::*;
#(
   parameter int unsigned          DATA_W      = 8,
   parameter int unsigned          MAX_RUN     = 9,
   parameter int unsigned          MIN_ENC     = 3,
   parameter logic [DATA_W-1:0]    ESC_CHAR    = 'h40,
   parameter logic [DATA_W-1:0]    DIGIT_BASE  = 'h30,
   parameter bit                   FAST_REFILL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_data,
   input  logic                in_last,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [DATA_W-1:0]   out_data,
   output logic                out_last
);

   localparam int unsigned LEN_W = $clog2(MAX_RUN + 1);

   if (DATA_W < 7) begin : g_bad_width
      $error("rle_escape_encoder: DATA_W must hold an ASCII code");
   end
   if (MAX_RUN < 2 || MAX_RUN > 9) begin : g_bad_max
      $error("rle_escape_encoder: MAX_RUN must be a single decimal digit of at least 2");
   end
   if (MIN_ENC < 2 || MIN_ENC > TOKEN_SLOTS + 1 || MIN_ENC > MAX_RUN) begin : g_bad_min
      $error("rle_escape_encoder: MIN_ENC out of range");
   end

   logic                               can_load;
   logic [DATA_W-1:0]                  run_char;
   logic [LEN_W-1:0]                   run_len;
   logic                               load;
   logic                               load_last;
   logic [TOKEN_SLOTS-1:0][DATA_W-1:0] tok_sym;
   logic [1:0]                         tok_cnt;
   token_kind_t                        tok_kind;

   rle_run_tracker #(
      .DATA_W   (DATA_W),
      .LEN_W    (LEN_W),
      .MAX_RUN  (MAX_RUN),
      .ESC_CHAR (ESC_CHAR)
   ) u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .can_load  (can_load),
      .run_char  (run_char),
      .run_len   (run_len),
      .load      (load),
      .load_last (load_last)
   );

   rle_token_builder #(
      .DATA_W     (DATA_W),
      .LEN_W      (LEN_W),
      .MIN_ENC    (MIN_ENC),
      .ESC_CHAR   (ESC_CHAR),
      .DIGIT_BASE (DIGIT_BASE)
   ) u_builder (
      .run_char (run_char),
      .run_len  (run_len),
      .tok_sym  (tok_sym),
      .tok_cnt  (tok_cnt),
      .tok_kind (tok_kind)
   );

   rle_symbol_emitter #(
      .DATA_W      (DATA_W),
      .FAST_REFILL (FAST_REFILL)
   ) u_emitter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ld_sym    (tok_sym),
      .ld_cnt    (tok_cnt),
      .ld_last   (load_last),
      .can_load  (can_load),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   AST_COUNTED_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (load && tok_kind == TK_COUNTED) |-> (tok_sym[0] == ESC_CHAR &&
         tok_sym[2] >= DIGIT_BASE + DATA_W'(MIN_ENC) &&
         tok_sym[2] <= DIGIT_BASE + DATA_W'(MAX_RUN))); // R3

endmodule

// File: tb/test_rle_escape_encoder.sv
module test_rle_escape_encoder;

   localparam int unsigned CYCLE_LIMIT = 150000;
   localparam logic [7:0]  MARK        = 8'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_data;
   logic       out_last;

   int compared = 0;
   int mismatched = 0;

   logic [7:0] in_q[$];
   bit         in_last_q[$];
   logic [7:0] exp_data[$];
   bit         exp_last[$];
   string      exp_tag[$];

   always #10 clk = ~clk;

   rle_escape_encoder i_rle_escape_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   task automatic push_exp(input logic [7:0] d, input string tag);
      exp_data.push_back(d);
      exp_last.push_back(1'b0);
      exp_tag.push_back(tag);
   endtask

   // Reference: encode one packet from the requirements.
   task automatic add_pkt(input logic [7:0] p[$], input string tag);
      int i = 0;
      while (i < p.size()) begin
         logic [7:0] c = p[i];
         int len = 1;
         if (c != MARK) begin
            while (i + len < p.size() && p[i+len] == c && len < 9) len++;
         end
         if (c == MARK) begin
            push_exp(MARK, tag); push_exp(MARK, tag); push_exp(8'h31, tag);
         end else if (len >= 3) begin
            push_exp(MARK, tag); push_exp(c, tag); push_exp(8'h30 + 8'(len), tag);
         end else begin
            for (int k = 0; k < len; k++) push_exp(c, tag);
         end
         i += len;
      end
      exp_last[exp_last.size()-1] = 1'b1;
      for (int k = 0; k < p.size(); k++) begin
         in_q.push_back(p[k]);
         in_last_q.push_back(k == p.size() - 1);
      end
   endtask

   task automatic add_str(input string s, input string tag);
      logic [7:0] p[$];
      for (int k = 0; k < s.len(); k++) p.push_back(s[k]);
      add_pkt(p, tag);
   endtask

   task automatic add_rep(input logic [7:0] c, input int n, input string tag);
      logic [7:0] p[$];
      for (int k = 0; k < n; k++) p.push_back(c);
      add_pkt(p, tag);
   endtask

   task automatic fail_line(input string tag, input string what, input int act, input int exp);
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
   endtask

   initial begin
      int cycle = 0;
      int idx = 0;
      bit pending = 1'b0;
      bit prev_stall = 1'b0;
      logic [7:0] prev_data = 8'h00;
      bit prev_last = 1'b0;

      // Packet set.
      add_str("ddeeeeeeeff", "R3");
      add_str("x", "R1");
      add_str("abbc", "R2");
      add_rep("a", 12, "R4");
      add_rep("b", 9, "R4");
      add_rep("c", 10, "R4");
      add_str("@@x@", "R5");
      add_str("@", "R5");
      add_str("qqq", "R7");
      add_str("qq", "R7");
      add_str("abcdef", "R6");
      for (int n = 0; n < 40; n++) begin
         logic [7:0] p[$];
         int plen = 1 + ($urandom % 30);
         logic [7:0] c = "a";
         for (int k = 0; k < plen; k++) begin
            if ($urandom % 3 == 0) begin
               case ($urandom % 4)
                  0: c = "a";
                  1: c = "b";
                  2: c = MARK;
                  default: c = "z";
               endcase
            end
            p.push_back(c);
         end
         add_pkt(p, "R6");
      end

      repeat (3) @(negedge clk);
      #5;
      compared++;
      if (out_valid !== 1'b0) fail_line("R9", "out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      compared++;
      if (out_valid !== 1'b0) fail_line("R9", "out_valid after reset", int'(out_valid), 0);
      compared++;
      if (in_ready !== 1'b1) fail_line("R9", "in_ready after reset", int'(in_ready), 1);

      while (!(idx == in_q.size() && !pending && exp_data.size() == 0 && !out_valid)) begin
         @(negedge clk);
         cycle++;
         if (cycle > CYCLE_LIMIT) begin
            fail_line("R8", "watchdog expired, symbols left", exp_data.size(), 0);
            break;
         end
         if (!pending) begin
            if (idx < in_q.size() && ($urandom % 4 != 0)) begin
               in_valid = 1'b1;
               in_data  = in_q[idx];
               in_last  = in_last_q[idx];
               idx++;
               pending  = 1'b1;
            end else begin
               in_valid = 1'b0;
            end
         end
         if (cycle >= 300 && cycle < 340) out_ready = 1'b0;
         else out_ready = ($urandom % 10) < 7;
         #5;
         if (prev_stall) begin
            compared++;
            if (out_valid !== 1'b1 || out_data !== prev_data || out_last !== prev_last)
               fail_line("R8", "stalled symbol changed", {out_valid, out_last, out_data},
                         {1'b1, prev_last, prev_data});
         end
         if (out_valid && out_ready) begin
            compared++;
            if (exp_data.size() == 0) begin
               fail_line("R8", "extra symbol", out_data, 0);
            end else begin
               if (out_data !== exp_data[0] || out_last !== exp_last[0])
                  fail_line(exp_tag[0], "symbol/last", {out_last, out_data},
                            {exp_last[0], exp_data[0]});
               void'(exp_data.pop_front());
               void'(exp_last.pop_front());
               void'(exp_tag.pop_front());
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         prev_last  = out_last;
         if (pending && in_ready) pending = 1'b0;
      end

      // Nothing may appear once every expected symbol has left (R8).
      in_valid = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         out_ready = 1'b1;
         #5;
         compared++;
         if (out_valid !== 1'b0) fail_line("R8", "symbol after stream end", out_data, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule